// File: doc/BRIEF.md
# General-Purpose I/O Bank Register Controller

This block is the register side of a bank of up to 32 general-purpose I/O lines. A processor reaches it through a simple synchronous bus: a byte address, a write strobe, 32 bits of write data and 32 bits of read data. Each register holds one bit per line. From these registers the block drives the value and the output enable of every pad. It also brings the pad levels in through a two-stage synchronizer.

For every line, one register selects general I/O mode or interrupt mode. Another selects input or output direction. A third chooses whether a driven line takes its value from the output data register or from an alternate data source. Reading the input data word gives output lines their stored output bit and input lines their synchronized pad level.

The block also holds the interrupt settings: polarity, edge or level, single or both edges, and filter enable. It passes these to a separate sensing block. When that block reports an event on a line that is in interrupt mode, the matching sticky status bit is set. A per-line enable then decides whether the event raises the combined interrupt output.

Top module: `pinbank_ctrl`

## Requirements
- R1: Reset is synchronous and active high. Afterwards every register is 0: all lines are inputs in general I/O mode, output data is 0, and all interrupts are disabled. `pad_oe`, `bus_rdata` and `irq_out` are 0.
- R2: Writes to these byte offsets store the write data, limited to the implemented lines, and reads of the same offsets return it: 0x00 mode (1 = interrupt mode), 0x04 direction (1 = output), 0x08 output data, 0x20 polarity, 0x24 edge/level, 0x28 filter enable, 0x40 output source (0 = output data register, 1 = alternate data), 0x4C both-edge.
- R3: `pad_oe[i]` is 1 exactly when direction bit i is 1 and mode bit i is 0. It takes effect the cycle after the write.
- R4: `pad_out[i]` is `alt_data[i]` when source bit i is 1, and output data bit i otherwise. A value stored while the line is an input is already on the pad when output direction is enabled.
- R5: Reading offset 0x0C returns, per line, output data bit i if direction bit i is 1, otherwise the pad level. A pad change first appears in `bus_rdata` three clock edges after it is applied: two synchronizer stages plus the read register.
- R6: `bus_rdata` is registered. After a clock edge it holds the word at the address presented at that edge, as the state stood before any write on that same edge.
- R7: Status (read at 0x10) bit i is set when `sense_hit[i]` is 1 while mode bit i is 1. Writing a 1 to offset 0x14 clears that bit. A set and a clear on the same edge leave the bit set.
- R8: Writing a 1 to offset 0x1C enables interrupt bit i. Writing a 1 to offset 0x18 disables it. Zero bits in either write leave the enable unchanged. Reading 0x18 returns the enable bits.
- R9: `irq_out` is 1 exactly when some line has both its status bit and its enable bit set.
- R10: Offsets 0x14 and 0x1C read as 0. Any other unlisted offset reads as 0, and writes to it change nothing.
- R11: The `cfg_*` outputs always equal the mode, polarity, edge/level, both-edge and filter registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | N_LINES | Pad levels (asynchronous) |
| alt_data | input | N_LINES | Alternate output data source |
| sense_hit | input | N_LINES | Per-line event pulses from the sensing block |
| pad_out | output | N_LINES | Pad output value |
| pad_oe | output | N_LINES | Pad output enable |
| cfg_irq_mode | output | N_LINES | Interrupt mode per line |
| cfg_polarity | output | N_LINES | Polarity select to the sensing block |
| cfg_edge | output | N_LINES | Edge (1) or level (0) select |
| cfg_both | output | N_LINES | Both-edge select |
| cfg_filter | output | N_LINES | Filter enable |
| irq_out | output | 1 | Combined enabled interrupt |

## Verification
Register writes show on `pad_oe`, `pad_out`, the `cfg_*` outputs and `irq_out` one edge after the write. They show in a read one edge after the address is presented. The bench drives on falling edges and samples on the following falling edge, so each result is checked in the first cycle it is due. Pad changes are checked twice on the input data word: still old after two edges and new after three, which pins down the synchronizer depth. A set and a clear of one status bit on the same edge are driven together, and the bit is checked on the next read.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_MODE,
        RG_DIR,
        RG_DOUT,
        RG_DIN,
        RG_STAT,
        RG_CLR,
        RG_MASK,
        RG_UNMASK,
        RG_POL,
        RG_EDGE,
        RG_FILT,
        RG_SRC,
        RG_BOTH
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] pol;
        logic [DATA_W-1:0] lvl_edge;
        logic [DATA_W-1:0] filt;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] both;
    } cfg_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            8'h00:   s = RG_MODE;
            8'h04:   s = RG_DIR;
            8'h08:   s = RG_DOUT;
            8'h0C:   s = RG_DIN;
            8'h10:   s = RG_STAT;
            8'h14:   s = RG_CLR;
            8'h18:   s = RG_MASK;
            8'h1C:   s = RG_UNMASK;
            8'h20:   s = RG_POL;
            8'h24:   s = RG_EDGE;
            8'h28:   s = RG_FILT;
            8'h40:   s = RG_SRC;
            8'h4C:   s = RG_BOTH;
            default: s = RG_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] line_mask(input int n);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = (i < n);
        return m;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pinbank_cfg.sv
module pinbank_cfg
    import pinbank_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    localparam logic [DATA_W-1:0] LMASK = line_mask(N_LINES);

    logic [DATA_W-1:0] wv;
    assign wv = wdata & LMASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (sel)
                RG_MODE: cfg.mode     <= wv;
                RG_DIR:  cfg.dir      <= wv;
                RG_DOUT: cfg.dout     <= wv;
                RG_POL:  cfg.pol      <= wv;
                RG_EDGE: cfg.lvl_edge <= wv;
                RG_FILT: cfg.filt     <= wv;
                RG_SRC:  cfg.src      <= wv;
                RG_BOTH: cfg.both     <= wv;
                default: ;
            endcase
        end
    end

    // R2: a direction write is held on the following cycle
    assert_dir_store_R2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RG_DIR) |=> (cfg.dir == ($past(wdata) & LMASK)));

    // R10: a write to an unlisted offset leaves every setting alone
    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RG_NONE) |=> $stable(cfg));
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
    import pinbank_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  reg_sel_e           sel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [N_LINES-1:0] hit,
    input  logic [N_LINES-1:0] mode,
    output logic [N_LINES-1:0] status,
    output logic [N_LINES-1:0] enable,
    output logic               irq
);
    logic [N_LINES-1:0] set_v, clr_v, wv;

    assign wv    = wdata[N_LINES-1:0];
    assign set_v = hit & mode;
    assign clr_v = (we && sel == RG_CLR) ? wv : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_v) | set_v;
            if (we && sel == RG_MASK)
                enable <= enable & ~wv;
            else if (we && sel == RG_UNMASK)
                enable <= enable | wv;
        end
    end

    assign irq = |(status & enable);

    // R7: a reported event on an interrupt-mode line is latched, even against a clear
    assert_status_set_R7: assert property (@(posedge clk) disable iff (rst)
        (|(hit & mode)) |=> ((status & $past(hit & mode)) == $past(hit & mode)));

    // R7: a clear with no coincident event empties the bit
    assert_status_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RG_CLR) |=> ((status & $past(wdata[N_LINES-1:0] & ~(hit & mode))) == '0));

    // R8: enabling sets exactly the written ones without dropping others
    assert_unmask_R8: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RG_UNMASK) |=> (enable == ($past(enable) | $past(wdata[N_LINES-1:0]))));
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] pad_in,
    input  logic [N_LINES-1:0] alt_data,
    input  logic [N_LINES-1:0] sense_hit,
    output logic [N_LINES-1:0] pad_out,
    output logic [N_LINES-1:0] pad_oe,
    output logic [N_LINES-1:0] cfg_irq_mode,
    output logic [N_LINES-1:0] cfg_polarity,
    output logic [N_LINES-1:0] cfg_edge,
    output logic [N_LINES-1:0] cfg_both,
    output logic [N_LINES-1:0] cfg_filter,
    output logic               irq_out
);
    localparam int SYNC_STAGES = 2;

    reg_sel_e           sel;
    cfg_t               cfg;
    logic [N_LINES-1:0] pin_q, stat, ena;
    logic [N_LINES-1:0] dir, dout, src, din_view;

    assign sel = decode_addr(bus_addr);

    pinbank_cfg #(.N_LINES(N_LINES)) u_cfg (
        .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata), .cfg(cfg)
    );

    pinbank_irq #(.N_LINES(N_LINES)) u_irq (
        .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata),
        .hit(sense_hit), .mode(cfg.mode[N_LINES-1:0]),
        .status(stat), .enable(ena), .irq(irq_out)
    );

    pinbank_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pin_q)
    );

    assign dir  = cfg.dir[N_LINES-1:0];
    assign dout = cfg.dout[N_LINES-1:0];
    assign src  = cfg.src[N_LINES-1:0];

    genvar g;
    generate
        for (g = 0; g < N_LINES; g++) begin : g_line
            assign pad_out[g]  = src[g] ? alt_data[g] : dout[g];
            assign pad_oe[g]   = dir[g] & ~cfg.mode[g];
            assign din_view[g] = dir[g] ? dout[g] : pin_q[g];
        end
    endgenerate

    assign cfg_irq_mode = cfg.mode[N_LINES-1:0];
    assign cfg_polarity = cfg.pol[N_LINES-1:0];
    assign cfg_edge     = cfg.lvl_edge[N_LINES-1:0];
    assign cfg_both     = cfg.both[N_LINES-1:0];
    assign cfg_filter   = cfg.filt[N_LINES-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            case (sel)
                RG_MODE: bus_rdata <= cfg.mode;
                RG_DIR:  bus_rdata <= cfg.dir;
                RG_DOUT: bus_rdata <= cfg.dout;
                RG_DIN:  bus_rdata <= 32'(din_view);
                RG_STAT: bus_rdata <= 32'(stat);
                RG_MASK: bus_rdata <= 32'(ena);
                RG_POL:  bus_rdata <= cfg.pol;
                RG_EDGE: bus_rdata <= cfg.lvl_edge;
                RG_FILT: bus_rdata <= cfg.filt;
                RG_SRC:  bus_rdata <= cfg.src;
                RG_BOTH: bus_rdata <= cfg.both;
                default: bus_rdata <= '0;
            endcase
        end
    end

    // R1: the cycle after reset everything visible is quiet
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bus_rdata == '0 && pad_oe == '0 && !irq_out));

    // R3: a line switched to interrupt mode never drives
    assert_oe_io_only_R3: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & cfg_irq_mode) == '0));

    // R10: write-only and unlisted offsets return zero
    assert_wo_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (sel == RG_CLR || sel == RG_UNMASK || sel == RG_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 32;

    logic          clk = 0;
    logic          rst = 1;
    logic [7:0]    bus_addr = 8'h00;
    logic          bus_we = 0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pad_in = '0, alt_data = '0, sense_hit = '0;
    logic [NL-1:0] pad_out, pad_oe, cfg_irq_mode, cfg_polarity, cfg_edge, cfg_both, cfg_filter;
    logic          irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] m_mode, m_dir, m_dout, m_pol, m_edge, m_filt, m_src, m_both;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinbank_ctrl #(.N_LINES(NL)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .alt_data(alt_data), .sense_hit(sense_hit), .pad_out(pad_out),
        .pad_oe(pad_oe), .cfg_irq_mode(cfg_irq_mode), .cfg_polarity(cfg_polarity),
        .cfg_edge(cfg_edge), .cfg_both(cfg_both), .cfg_filter(cfg_filter),
        .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    function automatic logic [7:0] cfg_off(input int k);
        case (k)
            0: return 8'h00; 1: return 8'h04; 2: return 8'h08; 3: return 8'h20;
            4: return 8'h24; 5: return 8'h28; 6: return 8'h40; default: return 8'h4C;
        endcase
    endfunction

    function automatic logic [31:0] exp_oe();
        return m_dir & ~m_mode;
    endfunction

    function automatic logic [31:0] exp_out(input logic [31:0] alt);
        return (m_src & alt) | (~m_src & m_dout);
    endfunction

    function automatic logic [31:0] model_val(input int k);
        case (k)
            0: return m_mode; 1: return m_dir; 2: return m_dout; 3: return m_pol;
            4: return m_edge; 5: return m_filt; 6: return m_src; default: return m_both;
        endcase
    endfunction

    task automatic model_set(input int k, input logic [31:0] d);
        case (k)
            0: m_mode = d; 1: m_dir = d; 2: m_dout = d; 3: m_pol = d;
            4: m_edge = d; 5: m_filt = d; 6: m_src = d; default: m_both = d;
        endcase
    endtask

    task automatic model_clear();
        m_mode = 0; m_dir = 0; m_dout = 0; m_pol = 0;
        m_edge = 0; m_filt = 0; m_src = 0; m_both = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_clear();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r, seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1 oe", pad_oe, 0);
        chk("R1 irq", {31'b0, irq_out}, 0);
        chk("R1 rdata", bus_rdata, 0);
        rd(8'h18, r); chk("R1 enable", r, 0);
        rd(8'h04, r); chk("R1 dir", r, 0);

        // R2 R3 R4 R11: random configuration traffic
        for (int it = 0; it < 300; it++) begin
            int k;
            logic [31:0] d;
            k = int'($urandom_range(0, 7));
            d = $urandom();
            alt_data = $urandom();
            wr(cfg_off(k), d);
            model_set(k, d);
            chk("R3 oe", pad_oe, exp_oe());
            chk("R4 out", pad_out, exp_out(alt_data));
            chk("R11 mode", cfg_irq_mode, m_mode);
            chk("R11 pol", cfg_polarity, m_pol);
            chk("R11 edge", cfg_edge, m_edge);
            chk("R11 both", cfg_both, m_both);
            chk("R11 filt", cfg_filter, m_filt);
            rd(cfg_off(k), r);
            chk("R2 readback", r, model_val(k));
        end

        do_reset();
        chk("R1 oe after mid reset", pad_oe, 0);
        rd(8'h08, r); chk("R1 dout after mid reset", r, 0);

        // R4: stored value is on the pad when direction turns to output
        alt_data = '0;
        wr(8'h08, 32'h0000_0020); m_dout = 32'h20;
        chk("R4 oe still off", pad_oe, 0);
        wr(8'h04, 32'h0000_0020); m_dir = 32'h20;
        chk("R4 oe on", pad_oe, 32'h20);
        chk("R4 value with oe", pad_out & pad_oe, 32'h20);
        // R4: alternate source
        alt_data = 32'h0; wr(8'h40, 32'h20); m_src = 32'h20;
        chk("R4 alt source", pad_out, 32'h0);
        // R3: interrupt mode removes the drive
        wr(8'h00, 32'h20); m_mode = 32'h20;
        chk("R3 irq mode no oe", pad_oe, 0);

        do_reset();
        // R5: synchronizer latency on input lines
        pad_in = 32'h0;
        rd(8'h0C, r); chk("R5 pins low", r, 0);
        @(negedge clk); pad_in = 32'hA5A5_5A5A;
        @(negedge clk);
        @(negedge clk); chk("R5 not yet after two edges", bus_rdata, 0);
        @(negedge clk); chk("R5 visible after three edges", bus_rdata, 32'hA5A5_5A5A);
        // R5: mixed directions
        wr(8'h08, 32'h1234_ABCD); wr(8'h04, 32'h0000_FFFF);
        pad_in = 32'hF0F0_F0F0;
        repeat (3) @(negedge clk);
        rd(8'h0C, r); chk("R5 mixed", r, (32'h0000_FFFF & 32'h1234_ABCD) | (32'hFFFF_0000 & 32'hF0F0_F0F0));

        // R6: read sees state before a same-edge write
        @(negedge clk); bus_addr = 8'h20; bus_we = 1; bus_wdata = 32'hCAFE_0001;
        @(negedge clk); bus_we = 0;
        chk("R6 old value on write edge", bus_rdata, 0);
        @(negedge clk); chk("R6 new value next edge", bus_rdata, 32'hCAFE_0001);

        do_reset();
        // R7 R8 R9: interrupt status and enables
        wr(8'h00, 32'h0000_000F);
        @(negedge clk); sense_hit = 32'hFF; @(negedge clk); sense_hit = 0;
        rd(8'h10, r); chk("R7 set only in irq mode", r, 32'h0F);
        chk("R9 masked no irq", {31'b0, irq_out}, 0);
        wr(8'h1C, 32'h2);
        chk("R9 irq on after enable", {31'b0, irq_out}, 1);
        rd(8'h18, r); chk("R8 enable readback", r, 32'h2);
        wr(8'h1C, 32'h8);
        rd(8'h18, r); chk("R8 enable accumulates", r, 32'hA);
        wr(8'h18, 32'h2);
        rd(8'h18, r); chk("R8 disable one", r, 32'h8);
        wr(8'h14, 32'h9);
        rd(8'h10, r); chk("R7 clear", r, 32'h6);
        chk("R9 irq off after clear", {31'b0, irq_out}, 0);
        @(negedge clk); bus_addr = 8'h14; bus_we = 1; bus_wdata = 32'h4; sense_hit = 32'h4;
        @(negedge clk); bus_we = 0; sense_hit = 0;
        rd(8'h10, r); chk("R7 set beats clear", r, 32'h6);

        // R10: unmapped and write-only offsets
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        rd(8'h00, r); chk("R10 mode untouched", r, 32'h0F);
        rd(8'h04, r); chk("R10 dir untouched", r, 0);
        rd(8'h30, r); chk("R10 unmapped reads zero", r, 0);
        rd(8'h14, r); chk("R10 clear reads zero", r, 0);
        rd(8'h1C, r); chk("R10 unmask reads zero", r, 0);
        chk("R10 oe untouched", pad_oe, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule